// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare Unit

This block orders two IEEE-754 single-precision operands and reports how they relate. Each compare is launched by a one-cycle start strobe. One clock later the block raises a one-cycle result strobe. With it come a four-bit relation field (less, equal, greater, unordered), an invalid-operation cause bit, and a trap request that carries a fixed trap code.

Before any comparison, subnormal operands are flushed to zero. After the flush, zero and negative zero compare equal. A quiet NaN on either side yields "unordered" and raises no cause. A signalling NaN is handled by the invalid-trap enable input:
- When the enable is set, the cause bit is raised, no relation bit is set, and a trap is requested.
- When the enable is clear, the result is simply "unordered".

Every compare replaces the relation field and the cause bit completely. Nothing from an earlier compare carries over.

Top module: `fpcmp_unit`

## Requirements
- R1: After reset, `res_valid`, `trap_req`, `res_inv_cause` and `res_cond` are all zero, and `trap_code` reads 0.
- R2: A compare accepted at a clock edge with `start` high produces exactly one cycle of `res_valid`, visible after the next edge. No `res_valid` appears without `start`, and outputs hold their values between compares.
- R3: For ordered operands, exactly one bit of `res_cond` is set. The encoding is bit 0 = A less than B, bit 1 = equal, bit 2 = A greater than B, bit 3 = unordered. Infinities order beyond every finite value.
- R4: Operands of opposite sign order by sign (negative is less). When both are negative, the larger magnitude is the smaller value.
- R5: An operand with a zero exponent field (a subnormal) is treated as zero. Any two such operands compare equal, whatever their signs and fractions.
- R6: If either operand is a quiet NaN (exponent all ones, fraction MSB 1) and neither is a signalling NaN, the result is unordered (bit 3) with `res_inv_cause` 0, whatever `inv_en` is.
- R7: If either operand is a signalling NaN (exponent all ones, fraction nonzero with MSB 0) and `inv_en` is 1, then `res_inv_cause` is 1 and `res_cond` is 0.
- R8: If either operand is a signalling NaN and `inv_en` is 0, the result is unordered (bit 3) with `res_inv_cause` 0.
- R9: `trap_req` is high exactly in the result cycle of a compare that set `res_inv_cause`. While `trap_req` is high, `trap_code` is 0x1D0; otherwise it is 0.
- R10: Each compare clears the relation and cause left by the previous one before writing its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch a compare of `op_a` against `op_b` |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| inv_en | input | 1 | Invalid-operation trap enable |
| res_valid | output | 1 | One-cycle result strobe |
| res_cond | output | 4 | Relation: bit0 less, bit1 equal, bit2 greater, bit3 unordered |
| res_inv_cause | output | 1 | Invalid-operation cause |
| trap_req | output | 1 | Trap request, coincident with `res_valid` |
| trap_code | output | 12 | Trap code, 0x1D0 while `trap_req` is high |

## Verification
The hardest situations to reach from the ports are the ones where the NaN kind and the enable bit decide the outcome:
- A signalling NaN whose sign and fraction look like a quiet NaN apart from the fraction MSB.
- A signalling NaN paired with a quiet NaN, where the signalling one must win.

Directed vectors place a negative signalling NaN against a quiet NaN with the enable both set and clear. A following ordinary compare then confirms that the earlier cause and trap were cleared. Subnormal pairs with differing fractions and signs are applied to show that the flush happens before the equality test.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  // relation field bit positions
  localparam int unsigned COND_W = 4;
  localparam int unsigned CB_LT  = 0;
  localparam int unsigned CB_EQ  = 1;
  localparam int unsigned CB_GT  = 2;
  localparam int unsigned CB_UN  = 3;

  typedef struct packed {
    logic sign;
    logic zero;   // zero exponent: zero or flushed subnormal
    logic inf;
    logic qnan;
    logic snan;
  } opclass_t;
endpackage

// File: rtl/fpcmp_rst_sync.sv
module fpcmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned MAG_W = EXP_W + FRAC_W,
  localparam int unsigned OP_W  = MAG_W + 1
) (
  input  logic [OP_W-1:0]  op,
  output opclass_t         cls,
  output logic [MAG_W-1:0] mag
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              exp_none;

  always_comb begin
    exp_f    = op[OP_W-2 -: EXP_W];
    frac_f   = op[FRAC_W-1:0];
    exp_ones = &exp_f;
    exp_none = ~|exp_f;
    cls.sign = op[OP_W-1];
    cls.zero = exp_none;
    cls.inf  = exp_ones & ~|frac_f;
    cls.qnan = exp_ones & frac_f[FRAC_W-1];
    cls.snan = exp_ones & (|frac_f) & ~frac_f[FRAC_W-1];
    mag      = exp_none ? '0 : op[MAG_W-1:0];
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int unsigned MAG_W = 31
) (
  input  opclass_t          cls_a,
  input  opclass_t          cls_b,
  input  logic [MAG_W-1:0]  mag_a,
  input  logic [MAG_W-1:0]  mag_b,
  input  logic              inv_en,
  output logic [COND_W-1:0] cond,
  output logic              inv_cause
);
  logic neg_a, neg_b, a_bigger;

  always_comb begin
    cond      = '0;
    inv_cause = 1'b0;
    neg_a     = cls_a.sign & ~cls_a.zero;
    neg_b     = cls_b.sign & ~cls_b.zero;
    a_bigger  = mag_a > mag_b;
    if (cls_a.snan | cls_b.snan) begin
      if (inv_en) inv_cause     = 1'b1;
      else        cond[CB_UN]   = 1'b1;
    end else if (cls_a.qnan | cls_b.qnan) begin
      cond[CB_UN] = 1'b1;
    end else if (neg_a != neg_b) begin
      if (neg_a) cond[CB_LT] = 1'b1;
      else       cond[CB_GT] = 1'b1;
    end else if (mag_a == mag_b) begin
      cond[CB_EQ] = 1'b1;
    end else if (a_bigger ^ neg_a) begin
      cond[CB_GT] = 1'b1;
    end else begin
      cond[CB_LT] = 1'b1;
    end
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int unsigned EXP_W     = 8,
  parameter int unsigned FRAC_W    = 23,
  parameter int unsigned TRAP_W    = 12,
  parameter logic [TRAP_W-1:0] TRAP_CODE = 12'h1D0,
  localparam int unsigned MAG_W    = EXP_W + FRAC_W,
  localparam int unsigned OP_W     = MAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic              inv_en,
  output logic              res_valid,
  output logic [COND_W-1:0] res_cond,
  output logic              res_inv_cause,
  output logic              trap_req,
  output logic [TRAP_W-1:0] trap_code
);
  logic                  rst_n_s;
  logic [1:0][OP_W-1:0]  ops;
  opclass_t              cls   [2];
  logic [MAG_W-1:0]      mags  [2];
  logic [COND_W-1:0]     cond_c;
  logic                  cause_c;

  logic                  valid_d, valid_q;
  logic [COND_W-1:0]     cond_d,  cond_q;
  logic                  cause_d, cause_q;
  logic                  trap_d,  trap_q;

  fpcmp_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign ops = {op_b, op_a};

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
      .op(ops[g]), .cls(cls[g]), .mag(mags[g])
    );
  end

  fpcmp_order #(.MAG_W(MAG_W)) i_order (
    .cls_a(cls[0]), .cls_b(cls[1]),
    .mag_a(mags[0]), .mag_b(mags[1]),
    .inv_en(inv_en),
    .cond(cond_c), .inv_cause(cause_c)
  );

  // next state
  always_comb begin
    valid_d = start;
    trap_d  = start & cause_c;
    cond_d  = cond_q;
    cause_d = cause_q;
    if (start) begin
      cond_d  = cond_c;   // whole field replaced: old bits cleared
      cause_d = cause_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_q <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      trap_q  <= trap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cond_q  <= '0;
      cause_q <= 1'b0;
    end else if (start) begin
      cond_q  <= cond_d;
      cause_q <= cause_d;
    end
  end

  assign res_valid     = valid_q;
  assign res_cond      = cond_q;
  assign res_inv_cause = cause_q;
  assign trap_req      = trap_q;
  assign trap_code     = trap_q ? TRAP_CODE : '0;
endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk #(
  parameter int unsigned TRAP_W = 12,
  parameter logic [TRAP_W-1:0] TRAP_CODE = 12'h1D0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              inv_en,
  input logic              res_valid,
  input logic [3:0]        res_cond,
  input logic              res_inv_cause,
  input logic              trap_req,
  input logic [TRAP_W-1:0] trap_code
);
  assert_valid_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !res_valid);
  assert_single_relation_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_inv_cause) |-> ($countones(res_cond) == 1));
  assert_cause_no_relation_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_inv_cause |-> (res_cond == 4'b0000));
  assert_disabled_no_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !inv_en) |=> !res_inv_cause);
  assert_trap_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (res_valid && res_inv_cause && trap_code == TRAP_CODE));
  assert_trap_with_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_inv_cause) |-> trap_req);
  assert_trap_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (trap_code == '0));
endmodule

bind fpcmp_unit fpcmp_unit_chk #(.TRAP_W(TRAP_W), .TRAP_CODE(TRAP_CODE)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .inv_en(inv_en),
  .res_valid(res_valid), .res_cond(res_cond), .res_inv_cause(res_inv_cause),
  .trap_req(trap_req), .trap_code(trap_code)
);

// File: tb/test_fpcmp_unit.sv
module test_fpcmp_unit;
  localparam logic [3:0] LT = 4'b0001, EQ = 4'b0010, GT = 4'b0100, UN = 4'b1000;
  localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000,
    N1 = 32'hBF800000, N2 = 32'hC0000000, PZ = 32'h00000000, NZ = 32'h80000000,
    PDN = 32'h00000001, NDN = 32'h807FFFFF, MINN = 32'h00800000,
    PINF = 32'h7F800000, NINF = 32'hFF800000, PMAX = 32'h7F7FFFFF,
    QNAN = 32'h7FC00000, SNAN = 32'h7F800001, NSNAN = 32'hFFA00000;

  logic clk = 1'b0;
  logic rst_n, start, inv_en;
  logic [31:0] op_a, op_b;
  logic res_valid, res_inv_cause, trap_req;
  logic [3:0] res_cond;
  logic [11:0] trap_code;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fpcmp_unit i_fpcmp_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .inv_en(inv_en), .res_valid(res_valid), .res_cond(res_cond),
    .res_inv_cause(res_inv_cause), .trap_req(trap_req), .trap_code(trap_code)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // launch one compare and check the result cycle and the cycle after
  task automatic cmp(string req, logic [31:0] a, logic [31:0] b, logic en,
                     logic [3:0] e_cond, logic e_cause);
    @(negedge clk);
    op_a = a; op_b = b; inv_en = en; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_a = '0; op_b = '0; inv_en = 1'b0;
    chk(req, "valid", {31'b0, res_valid}, 32'd1);
    chk(req, "cond", {28'b0, res_cond}, {28'b0, e_cond});
    chk(req, "cause", {31'b0, res_inv_cause}, {31'b0, e_cause});
    chk("R9", "trap_req", {31'b0, trap_req}, {31'b0, e_cause});
    chk("R9", "trap_code", {20'b0, trap_code}, e_cause ? 32'h1D0 : 32'h0);
    @(negedge clk);
    chk("R2", "valid pulse end", {31'b0, res_valid}, 32'd0);
    chk("R9", "trap end", {31'b0, trap_req}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; inv_en = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    chk("R1", "valid", {31'b0, res_valid}, 0);
    chk("R1", "cond", {28'b0, res_cond}, 0);
    chk("R1", "cause", {31'b0, res_inv_cause}, 0);
    chk("R1", "trap", {31'b0, trap_req}, 0);
    chk("R1", "trap_code", {20'b0, trap_code}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ordered;   // R3
    cmp("R3", P1, P2, 1'b0, LT, 1'b0);
    cmp("R3", P2, P1, 1'b1, GT, 1'b0);
    cmp("R3", P2, P2, 1'b0, EQ, 1'b0);
    cmp("R3", PINF, PMAX, 1'b0, GT, 1'b0);
    cmp("R3", NINF, N2, 1'b1, LT, 1'b0);
    cmp("R3", PINF, PINF, 1'b0, EQ, 1'b0);
  endtask

  task automatic t_signs;     // R4
    cmp("R4", N1, P1, 1'b0, LT, 1'b0);
    cmp("R4", P1, N2, 1'b0, GT, 1'b0);
    cmp("R4", N2, N1, 1'b0, LT, 1'b0);
    cmp("R4", N1, N2, 1'b0, GT, 1'b0);
    cmp("R4", PZ, N1, 1'b0, GT, 1'b0);
  endtask

  task automatic t_zero_flush; // R5
    cmp("R5", PZ, NZ, 1'b0, EQ, 1'b0);
    cmp("R5", PDN, NDN, 1'b1, EQ, 1'b0);
    cmp("R5", PDN, PZ, 1'b0, EQ, 1'b0);
    cmp("R5", NDN, MINN, 1'b0, LT, 1'b0);
    cmp("R5", NDN, N1, 1'b0, GT, 1'b0);
  endtask

  task automatic t_qnan;       // R6
    cmp("R6", QNAN, P1, 1'b0, UN, 1'b0);
    cmp("R6", P1, QNAN, 1'b1, UN, 1'b0);
    cmp("R6", QNAN, QNAN, 1'b1, UN, 1'b0);
  endtask

  task automatic t_snan_en;    // R7, R9
    cmp("R7", SNAN, P1, 1'b1, 4'b0000, 1'b1);
    cmp("R7", QNAN, NSNAN, 1'b1, 4'b0000, 1'b1);
  endtask

  task automatic t_snan_dis;   // R8
    cmp("R8", P2, SNAN, 1'b0, UN, 1'b0);
    cmp("R8", NSNAN, QNAN, 1'b0, UN, 1'b0);
  endtask

  task automatic t_clear;      // R10, R2 hold
    cmp("R10", NSNAN, P1, 1'b1, 4'b0000, 1'b1);
    repeat (3) @(negedge clk);
    chk("R2", "hold cause", {31'b0, res_inv_cause}, 32'd1);
    chk("R2", "no valid idle", {31'b0, res_valid}, 32'd0);
    cmp("R10", P1, P1, 1'b0, EQ, 1'b0);
    cmp("R10", QNAN, P1, 1'b0, UN, 1'b0);
    cmp("R10", N1, P1, 1'b0, LT, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ordered();
    t_signs();
    t_zero_flush();
    t_qnan();
    t_snan_en();
    t_snan_dis();
    t_clear();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule